// File: doc/BRIEF.md
# Ethernet Receive Frame Gate

This block sits between a PHY-facing byte stream and a receive FIFO. It decides which received frames are kept. Bytes arrive one per cycle while `rxDv` is high, and `rxLast` marks the final byte of a frame. With that final byte comes `crcOk`, the checksum verdict produced elsewhere. The block writes bytes to FIFO memory through its own write pointer. It drops a whole frame by moving the pointer back to where that frame began, so a discarded frame leaves no trace in the committed region.

A frame is kept only when all of the following hold:
- its destination address matches the programmed station address (optionally ignoring the low nibble of the sixth address byte);
- its checksum is good;
- it is not the station's own transmission echoed back by the PHY in half duplex.

The block can keep the 4-byte checksum trailer or strip it. Stripping runs the bytes through a short holding pipeline. Each kept frame produces a single ready pulse, a committed pointer update and, unless masked, an interrupt pulse. Full duplex is the OR of an external pin and a configuration bit. There is no loopback path inside the block; any echo comes from the PHY.

Top module: `eth_rx_gate`

## Requirements
- R1: `fullDup` is 1 exactly when `dupPin` or `dupReg` is 1; half duplex is its complement.
- R2: Received bytes 0..5 are compared with `stationAddr[47:40]`, `[39:32]`, ... `[7:0]` in that order. Any mismatching bit rejects the frame: no `frmRdy` pulse, and `commitPtr` and the next write start address are unchanged.
- R3: With `relaxAddr`=1, bits [3:0] of byte 5 are not compared, so the frame is accepted when only those bits differ. Bits [7:4] of byte 5 and bytes 0..4 are still compared.
- R4: In half duplex with `ownDiscard`=1, a frame whose first byte arrives while `txActive`=1 produces no `wrEn` at all and no `frmRdy`.
- R5: In half duplex with `ownDiscard`=0, a frame received during `txActive` is stored and signalled like any other frame.
- R6: In full duplex, `txActive` has no effect, and a frame received during transmission is stored.
- R7: With `keepFcs`=1, all N bytes of an accepted frame are written in order at consecutive addresses starting at the previous `commitPtr`.
- R8: With `keepFcs`=0, only the first N-4 bytes of an accepted frame are written; the final 4 bytes never reach the FIFO.
- R9: A frame with `crcOk`=0 on its last byte, or with fewer than 6 bytes, is rejected. The next accepted frame is written starting at the same address the rejected one started at.
- R10: After reset `wrEn`, `frmRdy`, `rxIrq` are 0 and `commitPtr` is 0. For an accepted frame, the last write is visible in the cycle after the clock edge that samples the last byte. `frmRdy` is a one-cycle pulse in the following cycle, and `commitPtr` changes only in that cycle, to the address after the last stored byte.
- R11: `rxIrq` pulses together with `frmRdy` when `intDis`=0 and never asserts when `intDis`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxDv | input | 1 | Byte strobe, one byte per cycle |
| rxData | input | 8 | Received byte |
| rxLast | input | 1 | Marks the final byte of the frame |
| crcOk | input | 1 | Checksum verdict, valid with `rxLast` |
| txActive | input | 1 | Local transmitter busy |
| dupPin | input | 1 | External full-duplex strap |
| dupReg | input | 1 | Configuration full-duplex bit |
| ownDiscard | input | 1 | Drop own echoed frames in half duplex |
| relaxAddr | input | 1 | Ignore low nibble of address byte 5 |
| keepFcs | input | 1 | Store checksum trailer |
| intDis | input | 1 | Mask the receive interrupt |
| stationAddr | input | 48 | Station address, byte 0 in [47:40] |
| fullDup | output | 1 | Resolved duplex mode |
| wrEn | output | 1 | FIFO write strobe |
| wrAddr | output | PTR_W | FIFO write address |
| wrData | output | 8 | FIFO write data |
| commitPtr | output | PTR_W | End of committed data |
| frmRdy | output | 1 | Frame-complete pulse |
| rxIrq | output | 1 | Gated receive interrupt pulse |

## Verification
The final write of one frame and the first write of the next can land in consecutive cycles. A rewind at the end of a rejected frame can coincide with a pending write from the stripping pipeline. Both cases are provoked by running an accepted frame directly after a rejected one. The test then checks that the accepted frame's bytes appear at the rejected frame's start address, and that `commitPtr` moves by exactly the stored length. A dedicated timing check confirms that the last write comes one cycle before the ready pulse.

// File: rtl/ethrx_pkg.sv
package ethrx_pkg;
  typedef struct packed {
    logic first;   // byte opens a new frame
    logic take;    // byte enters datapath (not an own echo)
    logic commit;  // frame ends and is kept
    logic rewind;  // frame ends and is dropped
  } rxStrb_t;
endpackage

// File: rtl/ethrx_ctrl.sv
module ethrx_ctrl
  import ethrx_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rxDv,
  input  logic [7:0]              rxData,
  input  logic                    rxLast,
  input  logic                    crcOk,
  input  logic                    txActive,
  input  logic                    fullDup,
  input  logic                    ownDiscard,
  input  logic                    relaxAddr,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  output rxStrb_t                 strb
);
  localparam int IDX_W = $clog2(ADDR_BYTES + 1);

  logic             inFrame, addrOk, ownFrame;
  logic [IDX_W-1:0] byteIdx, idx;
  logic             first, ownNow, byteOk, okNow, goodEnd;
  logic [7:0]       refByte;
  int               sel;

  always_comb begin
    first  = rxDv && !inFrame;
    idx    = first ? '0 : byteIdx;
    ownNow = first ? (!fullDup && ownDiscard && txActive) : ownFrame;
    sel    = ADDR_BYTES - 1 - int'(idx);
    if (sel < 0) sel = 0;
    refByte = stationAddr[8*sel +: 8];
    if (relaxAddr && idx == IDX_W'(ADDR_BYTES - 1))
      byteOk = (rxData[7:4] == refByte[7:4]);
    else
      byteOk = (rxData == refByte);
    okNow   = (first || addrOk) && (idx >= IDX_W'(ADDR_BYTES) || byteOk);
    goodEnd = okNow && (idx >= IDX_W'(ADDR_BYTES - 1)) && crcOk && !ownNow;
    strb.first  = first;
    strb.take   = rxDv && !ownNow;
    strb.commit = rxDv && rxLast && goodEnd;
    strb.rewind = rxDv && rxLast && !goodEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame  <= 1'b0;
      byteIdx  <= '0;
      addrOk   <= 1'b0;
      ownFrame <= 1'b0;
    end else if (rxDv) begin
      inFrame  <= !rxLast;
      byteIdx  <= (idx < IDX_W'(ADDR_BYTES)) ? idx + 1'b1 : idx;
      addrOk   <= okNow;
      ownFrame <= ownNow;
    end
  end
endmodule

// File: rtl/ethrx_dp.sv
module ethrx_dp
  import ethrx_pkg::*;
#(
  parameter int PTR_W     = 6,
  parameter int FCS_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrb_t          strb,
  input  logic [7:0]       rxData,
  input  logic             keepFcs,
  input  logic             intDis,
  output logic             wrEn,
  output logic [PTR_W-1:0] wrAddr,
  output logic [7:0]       wrData,
  output logic [PTR_W-1:0] commitPtr,
  output logic             frmRdy,
  output logic             rxIrq
);
  localparam int FILL_W = $clog2(FCS_BYTES + 1);

  logic [7:0]       pipe [FCS_BYTES];
  logic [FILL_W-1:0] fill, fillEff;
  logic [PTR_W-1:0] ptr, basePtr, stagePtr, ptrNext;
  logic             stage, wen;

  always_comb begin
    fillEff = strb.first ? '0 : fill;
    wen     = strb.take && (keepFcs || fillEff == FILL_W'(FCS_BYTES));
    ptrNext = ptr + PTR_W'(wen);
  end

  always_ff @(posedge clk) begin
    if (strb.take) pipe[0] <= rxData;
  end

  for (genvar g = 1; g < FCS_BYTES; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (strb.take) pipe[g] <= pipe[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fill      <= '0;
      ptr       <= '0;
      basePtr   <= '0;
      stagePtr  <= '0;
      stage     <= 1'b0;
      wrEn      <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
      commitPtr <= '0;
      frmRdy    <= 1'b0;
      rxIrq     <= 1'b0;
    end else begin
      if (strb.take)
        fill <= (fillEff == FILL_W'(FCS_BYTES)) ? fillEff : fillEff + 1'b1;
      wrEn   <= wen;
      wrAddr <= ptr;
      wrData <= keepFcs ? rxData : pipe[FCS_BYTES-1];
      if (strb.commit) begin
        ptr      <= ptrNext;
        basePtr  <= ptrNext;
        stagePtr <= ptrNext;
      end else if (strb.rewind) begin
        ptr <= basePtr;
      end else begin
        ptr <= ptrNext;
      end
      stage  <= strb.commit;
      frmRdy <= stage;
      rxIrq  <= stage && !intDis;
      if (stage) commitPtr <= stagePtr;
    end
  end
endmodule

// File: rtl/eth_rx_gate.sv
module eth_rx_gate
  import ethrx_pkg::*;
#(
  parameter int PTR_W      = 6,
  parameter int ADDR_BYTES = 6,
  parameter int FCS_BYTES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rxDv,
  input  logic [7:0]              rxData,
  input  logic                    rxLast,
  input  logic                    crcOk,
  input  logic                    txActive,
  input  logic                    dupPin,
  input  logic                    dupReg,
  input  logic                    ownDiscard,
  input  logic                    relaxAddr,
  input  logic                    keepFcs,
  input  logic                    intDis,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  output logic                    fullDup,
  output logic                    wrEn,
  output logic [PTR_W-1:0]        wrAddr,
  output logic [7:0]              wrData,
  output logic [PTR_W-1:0]        commitPtr,
  output logic                    frmRdy,
  output logic                    rxIrq
);
  rxStrb_t strb;

  assign fullDup = dupPin | dupReg;

  ethrx_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxDv(rxDv), .rxData(rxData), .rxLast(rxLast),
    .crcOk(crcOk), .txActive(txActive), .fullDup(fullDup),
    .ownDiscard(ownDiscard), .relaxAddr(relaxAddr),
    .stationAddr(stationAddr), .strb(strb)
  );

  ethrx_dp #(.PTR_W(PTR_W), .FCS_BYTES(FCS_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxData(rxData),
    .keepFcs(keepFcs), .intDis(intDis), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .commitPtr(commitPtr), .frmRdy(frmRdy), .rxIrq(rxIrq)
  );
endmodule

// File: rtl/ethrx_chk.sv
module ethrx_chk #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             intDis,
  input logic             frmRdy,
  input logic             rxIrq,
  input logic [PTR_W-1:0] commitPtr
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> !$past(intDis)); // R11
  AST_IRQ_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> frmRdy); // R11
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    frmRdy |=> !frmRdy); // R10
  AST_COMMIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !frmRdy |-> $stable(commitPtr)); // R10
endmodule

bind eth_rx_gate ethrx_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .intDis(intDis), .frmRdy(frmRdy),
  .rxIrq(rxIrq), .commitPtr(commitPtr)
);

// File: tb/eth_rx_gate_tb.sv
module eth_rx_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] STA = 48'h02_1A_3C_4D_5E_6F;

  logic clk = 1'b0, rstN = 1'b0;
  logic rxDv = 0, rxLast = 0, crcOk = 1, txActive = 0;
  logic dupPin = 0, dupReg = 0, ownDiscard = 0, relaxAddr = 0;
  logic keepFcs = 1, intDis = 0;
  logic [7:0] rxData = '0;
  logic fullDup, wrEn, frmRdy, rxIrq;
  logic [5:0] wrAddr, commitPtr;
  logic [7:0] wrData;

  int checks = 0, failures = 0, cycles = 0;
  int wrCnt = 0, rdyCnt = 0, irqCnt = 0;
  logic [7:0] mem [64];
  logic [7:0] fr [64];
  logic [5:0] expPtr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_gate u_dut (
    .clk(clk), .rstN(rstN), .rxDv(rxDv), .rxData(rxData), .rxLast(rxLast),
    .crcOk(crcOk), .txActive(txActive), .dupPin(dupPin), .dupReg(dupReg),
    .ownDiscard(ownDiscard), .relaxAddr(relaxAddr), .keepFcs(keepFcs),
    .intDis(intDis), .stationAddr(STA), .fullDup(fullDup), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .commitPtr(commitPtr),
    .frmRdy(frmRdy), .rxIrq(rxIrq)
  );

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (wrEn) begin mem[wrAddr] = wrData; wrCnt++; end
      if (frmRdy) rdyCnt++;
      if (rxIrq) irqCnt++;
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: run did not finish (act=%0d exp<=100000)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Sends one frame; modIdx>=0 xors modVal into that byte.
  task automatic runFrame(input int len, input bit good, input int modIdx,
                          input logic [7:0] modVal, input bit accept,
                          input bit noWrite, input bit timing, input string req);
    int rdy0 = rdyCnt, irq0 = irqCnt, wr0 = wrCnt;
    int stored = keepFcs ? len : len - 4;
    for (int i = 0; i < len; i++) begin
      fr[i] = (i < 6) ? STA[8*(5-i) +: 8] : 8'(i * 29 + 7 + int'(expPtr));
      if (i == modIdx) fr[i] = fr[i] ^ modVal;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxDv = 1; rxData = fr[i]; rxLast = (i == len - 1); crcOk = good;
    end
    @(negedge clk);
    rxDv = 0; rxLast = 0; crcOk = 1;
    if (timing) begin
      chk(wrEn === 1'b1 && frmRdy === 1'b0, "R10", "last write before ready",
          int'(frmRdy), 0);
      @(negedge clk);
      chk(frmRdy === 1'b1 && wrEn === 1'b0, "R10", "ready pulse cycle", int'(frmRdy), 1);
      @(negedge clk);
      chk(frmRdy === 1'b0, "R10", "ready single cycle", int'(frmRdy), 0);
    end
    repeat (4) @(negedge clk);
    if (accept) begin
      chk(rdyCnt - rdy0 == 1, req, "ready pulses", rdyCnt - rdy0, 1);
      chk(irqCnt - irq0 == (intDis ? 0 : 1), "R11", "irq pulses", irqCnt - irq0,
          intDis ? 0 : 1);
      chk(wrCnt - wr0 == stored, req, "bytes written", wrCnt - wr0, stored);
      chk(commitPtr == expPtr + 6'(stored), req, "commitPtr", int'(commitPtr),
          int'(expPtr + 6'(stored)));
      for (int i = 0; i < stored; i++) begin
        logic [5:0] a = expPtr + 6'(i);
        if (mem[a] !== fr[i]) chk(0, req, "stored byte", int'(mem[a]), int'(fr[i]));
      end
      expPtr = expPtr + 6'(stored);
    end else begin
      chk(rdyCnt - rdy0 == 0, req, "no ready on reject", rdyCnt - rdy0, 0);
      chk(commitPtr == expPtr, req, "commitPtr kept", int'(commitPtr), int'(expPtr));
      if (noWrite) chk(wrCnt - wr0 == 0, req, "no writes", wrCnt - wr0, 0);
    end
  endtask

  task automatic tReset();
    chk(wrEn === 1'b0 && frmRdy === 1'b0 && rxIrq === 1'b0, "R10", "reset strobes",
        int'(wrEn) + int'(frmRdy) + int'(rxIrq), 0);
    chk(commitPtr === 6'd0, "R10", "reset commitPtr", int'(commitPtr), 0);
  endtask

  task automatic tDuplex();
    for (int k = 0; k < 4; k++) begin
      dupPin = k[0]; dupReg = k[1];
      #1;
      chk(fullDup === (k != 0), "R1", "duplex OR", int'(fullDup), int'(k != 0));
    end
    dupPin = 0; dupReg = 0;
  endtask

  task automatic tKeep();
    keepFcs = 1;
    runFrame(12, 1, -1, 8'h00, 1, 0, 1, "R7");
  endtask

  task automatic tStrip();
    keepFcs = 0;
    runFrame(12, 1, -1, 8'h00, 1, 0, 0, "R8");
  endtask

  task automatic tMismatch();
    keepFcs = 0;
    runFrame(12, 1, 2, 8'h10, 0, 0, 0, "R2");
    runFrame(10, 1, -1, 8'h00, 1, 0, 0, "R2");
  endtask

  task automatic tRelax();
    keepFcs = 1;
    relaxAddr = 1;
    runFrame(9, 1, 5, 8'h0A, 1, 0, 0, "R3");
    runFrame(9, 1, 5, 8'h20, 0, 0, 0, "R3");
    relaxAddr = 0;
    runFrame(9, 1, 5, 8'h0A, 0, 0, 0, "R3");
  endtask

  task automatic tCrcShort();
    keepFcs = 1;
    runFrame(11, 0, -1, 8'h00, 0, 0, 0, "R9");
    runFrame(5, 1, -1, 8'h00, 0, 0, 0, "R9");
    runFrame(8, 1, -1, 8'h00, 1, 0, 0, "R9");
  endtask

  task automatic tOwn();
    keepFcs = 1;
    ownDiscard = 1; txActive = 1;
    runFrame(10, 1, -1, 8'h00, 0, 1, 0, "R4");
    ownDiscard = 0;
    runFrame(10, 1, -1, 8'h00, 1, 0, 0, "R5");
    ownDiscard = 1; dupPin = 1;
    runFrame(10, 1, -1, 8'h00, 1, 0, 0, "R6");
    dupPin = 0; dupReg = 1;
    runFrame(7, 1, -1, 8'h00, 1, 0, 0, "R6");
    dupReg = 0; txActive = 0; ownDiscard = 0;
  endtask

  task automatic tIrqMask();
    keepFcs = 0;
    intDis = 1;
    runFrame(11, 1, -1, 8'h00, 1, 0, 0, "R11");
    intDis = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tDuplex();
    tKeep();
    tStrip();
    tMismatch();
    tRelax();
    tCrcShort();
    tOwn();
    tIrqMask();
    tKeep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule